// File: doc/BRIEF.md
# Dual-Slot Instruction Word Dispatcher

This block sits between instruction fetch and the execution units of a core. The core packs its instructions into 32-bit words. A word carries either one long instruction or two 15-bit short instructions, one in a left slot and one in a right slot. The dispatcher accepts one word at a time. It then presents the word's contents as a series of issue events, one per clock, over a valid/ready handshake. Each event carries a slot tag, a payload, the opcode class index of the instruction and its position in the word (first or second).

Two bits at the top of the word select the issue pattern: a single long issue, two serial issues in either order, or a parallel pair. When the first event of a word completes, the execution side reports whether that instruction changed the program counter, raised an exception, or produced a true condition. From these flags the dispatcher decides whether the second event is issued at all. In a parallel pair, one slot can be a condition-test instruction, and the other slot then executes only when the test comes out true. Which opcode classes count as condition tests is set by a 64-bit class map parameter. Single-cycle event strobes report the word format, the outcome of each conditional test and each branch-skipped second slot, so that external counters can tally them.

Top module: `wdisp_top`

## Requirements
- R1: A word whose bits 31:30 are 11 produces exactly one issue: slot tag 2 (long), position 0, payload equal to word bits 29:0, class index equal to word bits 29:24.
- R2: A word with format 01 issues the left short (word bits 29:15, slot tag 0) at position 0 and then the right short (word bits 14:0, slot tag 1) at position 1. A short payload is the 15-bit instruction zero-extended to 30 bits, and its class index is the short's bits 14:9.
- R3: A word with format 10 issues the right short at position 0 and then the left short at position 1.
- R4: In either serial format, the second issue is dropped when the first issue's handshake reports a PC change or an exception. A PC change without an exception also pulses ev_jump_skip.
- R5: In format 00, when neither short has a condition-test class, the left short is issued first and the right second. The right issue is dropped only on an exception; a PC change has no effect.
- R6: In format 00, when the left short has a condition-test class, it is issued first. The right short is issued only if fb_cond_true is high at that handshake. ev_cond_true or ev_cond_false pulses with the outcome.
- R7: In format 00, when only the right short has a condition-test class, the right short is issued first and the left short only on a true condition. If both shorts are tests, the left short tests.
- R8: word_ready is high only when no issue is pending. An accepted word presents its first issue in the next cycle. While iss_valid is high and iss_ready is low, the slot, position and payload hold their values.
- R9: One cycle after a word is accepted, exactly one of ev_long, ev_serial_lr, ev_serial_rl or ev_parallel pulses for one cycle, matching formats 11, 01, 10 and 00.
- R10: After reset, word_ready is high, iss_valid is low and all event strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Fetched word available |
| word_ready | output | 1 | Dispatcher can take a word |
| word_data | input | 32 | Fetched instruction word |
| iss_valid | output | 1 | Issue event presented |
| iss_ready | input | 1 | Execution side takes the issue |
| iss_slot | output | 2 | 0 left, 1 right, 2 long |
| iss_pos | output | 1 | 0 first, 1 second issue of the word |
| iss_payload | output | 30 | Instruction bits, shorts zero-extended |
| iss_class | output | 6 | Opcode class index |
| fb_pc_changed | input | 1 | Issued instruction changed the PC (sampled at handshake) |
| fb_exception | input | 1 | Issued instruction raised an exception |
| fb_cond_true | input | 1 | Condition-test result of the issued instruction |
| ev_long | output | 1 | Long-format word accepted |
| ev_serial_lr | output | 1 | Left-first serial word accepted |
| ev_serial_rl | output | 1 | Right-first serial word accepted |
| ev_parallel | output | 1 | Parallel word accepted |
| ev_cond_true | output | 1 | Parallel test came out true |
| ev_cond_false | output | 1 | Parallel test came out false |
| ev_jump_skip | output | 1 | Serial second slot skipped by a PC change |

## Verification
Two functions can meet in one handshake cycle. A serial first issue may report a PC change and an exception together, and only the exception outcome may count: the issue is suppressed, but no jump-skip pulse follows. The bench provokes this with both flags high on a left-first word. It then checks that iss_valid falls and ev_jump_skip stays low. The same meeting of functions happens in a parallel test slot that raises an exception while its condition is false, where the condition outcome must decide the suppression and the false-condition strobe.

// File: rtl/wdisp_pkg.sv
package wdisp_pkg;
   typedef enum logic [1:0] {
      FMT_PAR  = 2'b00,
      FMT_LR   = 2'b01,
      FMT_RL   = 2'b10,
      FMT_LONG = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      SLOT_L    = 2'd0,
      SLOT_R    = 2'd1,
      SLOT_LONG = 2'd2
   } slot_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } state_e;

   typedef enum logic [1:0] {
      PM_PLAIN = 2'd0,
      PM_LTEST = 2'd1,
      PM_RTEST = 2'd2
   } pmode_e;
endpackage

// File: rtl/wdisp_decode.sv
module wdisp_decode
   import wdisp_pkg::*;
#(
   parameter int SHORT_W = 15,
   parameter int CLASS_W = 6,
   parameter logic [(2**CLASS_W)-1:0] TEST_MAP = '0,
   localparam int WORD_W = 2 * SHORT_W + 2
) (
   input  logic [WORD_W-1:0]  word,
   output fmt_e               fmt,
   output logic [SHORT_W-1:0] left_ins,
   output logic [SHORT_W-1:0] right_ins,
   output logic [CLASS_W-1:0] left_cls,
   output logic [CLASS_W-1:0] right_cls,
   output pmode_e             pmode,
   output logic               first_right
);
   logic left_test, right_test;

   always_comb begin
      fmt        = fmt_e'(word[WORD_W-1 -: 2]);
      left_ins   = word[2*SHORT_W-1 -: SHORT_W];
      right_ins  = word[SHORT_W-1:0];
      left_cls   = left_ins[SHORT_W-1 -: CLASS_W];
      right_cls  = right_ins[SHORT_W-1 -: CLASS_W];
      left_test  = TEST_MAP[left_cls];
      right_test = TEST_MAP[right_cls];
      if (left_test)       pmode = PM_LTEST;
      else if (right_test) pmode = PM_RTEST;
      else                 pmode = PM_PLAIN;
      first_right = (fmt == FMT_RL) || ((fmt == FMT_PAR) && (pmode == PM_RTEST));
   end
endmodule

// File: rtl/wdisp_slot_mux.sv
module wdisp_slot_mux
   import wdisp_pkg::*;
#(
   parameter int SHORT_W = 15,
   parameter int CLASS_W = 6,
   localparam int PAY_W = 2 * SHORT_W
) (
   input  fmt_e               fmt,
   input  logic               second,
   input  logic               first_right,
   input  logic [PAY_W-1:0]   body,
   input  logic [SHORT_W-1:0] left_ins,
   input  logic [SHORT_W-1:0] right_ins,
   input  logic [CLASS_W-1:0] left_cls,
   input  logic [CLASS_W-1:0] right_cls,
   output slot_e              slot,
   output logic [PAY_W-1:0]   payload,
   output logic [CLASS_W-1:0] cls
);
   logic take_right;

   always_comb begin
      take_right = first_right ^ second;
      if (fmt == FMT_LONG) begin
         slot    = SLOT_LONG;
         payload = body;
         cls     = left_cls;
      end else if (take_right) begin
         slot    = SLOT_R;
         payload = {{(PAY_W-SHORT_W){1'b0}}, right_ins};
         cls     = right_cls;
      end else begin
         slot    = SLOT_L;
         payload = {{(PAY_W-SHORT_W){1'b0}}, left_ins};
         cls     = left_cls;
      end
   end
endmodule

// File: rtl/wdisp_events.sv
module wdisp_events
   import wdisp_pkg::*;
#(
   parameter bit EV_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  fmt_e acc_fmt,
   input  logic test_done,
   input  logic cond,
   input  logic jump_done,
   output logic [6:0] ev
);
   logic [6:0] ev_d;

   always_comb begin
      ev_d    = '0;
      ev_d[0] = accept && (acc_fmt == FMT_LONG);
      ev_d[1] = accept && (acc_fmt == FMT_LR);
      ev_d[2] = accept && (acc_fmt == FMT_RL);
      ev_d[3] = accept && (acc_fmt == FMT_PAR);
      ev_d[4] = test_done && cond;
      ev_d[5] = test_done && !cond;
      ev_d[6] = jump_done;
   end

   generate
      if (EV_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) ev <= '0;
            else        ev <= ev_d;
         end
      end else begin : g_comb
         assign ev = ev_d;
      end
   endgenerate
endmodule

// File: rtl/wdisp_top.sv
module wdisp_top
   import wdisp_pkg::*;
#(
   parameter int SHORT_W = 15,
   parameter int CLASS_W = 6,
   parameter logic [(2**CLASS_W)-1:0] TEST_MAP = 64'h0000_0000_0000_0030,
   parameter bit EV_REG = 1'b1,
   localparam int PAY_W  = 2 * SHORT_W,
   localparam int WORD_W = PAY_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   output logic               word_ready,
   input  logic [WORD_W-1:0]  word_data,
   output logic               iss_valid,
   input  logic               iss_ready,
   output logic [1:0]         iss_slot,
   output logic               iss_pos,
   output logic [PAY_W-1:0]   iss_payload,
   output logic [CLASS_W-1:0] iss_class,
   input  logic               fb_pc_changed,
   input  logic               fb_exception,
   input  logic               fb_cond_true,
   output logic               ev_long,
   output logic               ev_serial_lr,
   output logic               ev_serial_rl,
   output logic               ev_parallel,
   output logic               ev_cond_true,
   output logic               ev_cond_false,
   output logic               ev_jump_skip
);
   generate
      if (CLASS_W > SHORT_W) begin : g_bad_class
         $error("wdisp_top: CLASS_W must not exceed SHORT_W");
      end
      if (SHORT_W < 2) begin : g_bad_short
         $error("wdisp_top: SHORT_W too small");
      end
   endgenerate

   state_e             st_q, st_d;
   logic [WORD_W-1:0]  word_q;
   fmt_e               fmt, acc_fmt;
   logic [SHORT_W-1:0] left_ins, right_ins;
   logic [CLASS_W-1:0] left_cls, right_cls;
   pmode_e             pmode;
   logic               first_right;
   slot_e              slot;
   logic               accept, hs, first_hs, go_second;
   logic               test_done, jump_done;
   logic [6:0]         ev;

   wdisp_decode #(.SHORT_W(SHORT_W), .CLASS_W(CLASS_W), .TEST_MAP(TEST_MAP)) u_dec (
      .word        (word_q),
      .fmt         (fmt),
      .left_ins    (left_ins),
      .right_ins   (right_ins),
      .left_cls    (left_cls),
      .right_cls   (right_cls),
      .pmode       (pmode),
      .first_right (first_right)
   );

   wdisp_slot_mux #(.SHORT_W(SHORT_W), .CLASS_W(CLASS_W)) u_mux (
      .fmt         (fmt),
      .second      (st_q == ST_SECOND),
      .first_right (first_right),
      .body        (word_q[PAY_W-1:0]),
      .left_ins    (left_ins),
      .right_ins   (right_ins),
      .left_cls    (left_cls),
      .right_cls   (right_cls),
      .slot        (slot),
      .payload     (iss_payload),
      .cls         (iss_class)
   );

   assign word_ready = (st_q == ST_IDLE);
   assign iss_valid  = (st_q != ST_IDLE);
   assign iss_pos    = (st_q == ST_SECOND);
   assign iss_slot   = slot;
   assign accept     = word_valid && word_ready;
   assign hs         = iss_valid && iss_ready;
   assign first_hs   = hs && (st_q == ST_FIRST);
   assign acc_fmt    = fmt_e'(word_data[WORD_W-1 -: 2]);

   always_comb begin
      unique case (fmt)
         FMT_LONG:       go_second = 1'b0;
         FMT_LR, FMT_RL: go_second = !fb_pc_changed && !fb_exception;
         default:        go_second = (pmode == PM_PLAIN) ? !fb_exception : fb_cond_true;
      endcase
   end

   assign test_done = first_hs && (fmt == FMT_PAR) && (pmode != PM_PLAIN);
   assign jump_done = first_hs && ((fmt == FMT_LR) || (fmt == FMT_RL))
                      && fb_pc_changed && !fb_exception;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (accept) st_d = ST_FIRST;
         ST_FIRST:  if (hs)     st_d = go_second ? ST_SECOND : ST_IDLE;
         ST_SECOND: if (hs)     st_d = ST_IDLE;
         default:               st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         word_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) word_q <= word_data;
      end
   end

   wdisp_events #(.EV_REG(EV_REG)) u_ev (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_fmt   (acc_fmt),
      .test_done (test_done),
      .cond      (fb_cond_true),
      .jump_done (jump_done),
      .ev        (ev)
   );

   assign ev_long       = ev[0];
   assign ev_serial_lr  = ev[1];
   assign ev_serial_rl  = ev[2];
   assign ev_parallel   = ev[3];
   assign ev_cond_true  = ev[4];
   assign ev_cond_false = ev[5];
   assign ev_jump_skip  = ev[6];
endmodule

// File: rtl/wdisp_checker.sv
module wdisp_checker #(
   parameter int PAY_W   = 30,
   parameter int CLASS_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             word_valid,
   input logic             word_ready,
   input logic             iss_valid,
   input logic             iss_ready,
   input logic [1:0]       iss_slot,
   input logic             iss_pos,
   input logic [PAY_W-1:0] iss_payload,
   input logic             fb_exception,
   input logic             fb_cond_true,
   input logic             ev_long,
   input logic             ev_serial_lr,
   input logic             ev_serial_rl,
   input logic             ev_parallel,
   input logic             ev_cond_true,
   input logic             ev_cond_false
);
   AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      word_ready |-> !iss_valid); // R8
   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid && word_ready |=> iss_valid && !iss_pos); // R8
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && !iss_ready |=> iss_valid && $stable(iss_slot) && $stable(iss_pos)
                                  && $stable(iss_payload)); // R8
   AST_LONG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && (iss_slot == 2'd2) |-> !iss_pos); // R1
   AST_SECOND_OTHER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_ready && !iss_pos && (iss_slot != 2'd2)
      |=> !iss_valid || (iss_slot != $past(iss_slot))); // R2
   AST_EXC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && iss_ready && !iss_pos && fb_exception && !fb_cond_true
      |=> !iss_valid); // R4
   AST_FMT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_long, ev_serial_lr, ev_serial_rl, ev_parallel})); // R9
   AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_cond_true && ev_cond_false)); // R6
endmodule

bind wdisp_top wdisp_checker #(.PAY_W(PAY_W), .CLASS_W(CLASS_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .word_valid   (word_valid),
   .word_ready   (word_ready),
   .iss_valid    (iss_valid),
   .iss_ready    (iss_ready),
   .iss_slot     (iss_slot),
   .iss_pos      (iss_pos),
   .iss_payload  (iss_payload),
   .fb_exception (fb_exception),
   .fb_cond_true (fb_cond_true),
   .ev_long      (ev_long),
   .ev_serial_lr (ev_serial_lr),
   .ev_serial_rl (ev_serial_rl),
   .ev_parallel  (ev_parallel),
   .ev_cond_true (ev_cond_true),
   .ev_cond_false(ev_cond_false)
);

// File: tb/wdisp_top_tb_top.sv
module wdisp_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_valid = 1'b0;
   logic        word_ready;
   logic [31:0] word_data = '0;
   logic        iss_valid;
   logic        iss_ready = 1'b1;
   logic [1:0]  iss_slot;
   logic        iss_pos;
   logic [29:0] iss_payload;
   logic [5:0]  iss_class;
   logic        fb_pc = 1'b0, fb_exc = 1'b0, fb_cond = 1'b0;
   logic        ev_long, ev_lr, ev_rl, ev_par, ev_ct, ev_cf, ev_js;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   wdisp_top dut_i (
      .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
      .word_data(word_data), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_slot(iss_slot), .iss_pos(iss_pos), .iss_payload(iss_payload),
      .iss_class(iss_class), .fb_pc_changed(fb_pc), .fb_exception(fb_exc),
      .fb_cond_true(fb_cond), .ev_long(ev_long), .ev_serial_lr(ev_lr),
      .ev_serial_rl(ev_rl), .ev_parallel(ev_par), .ev_cond_true(ev_ct),
      .ev_cond_false(ev_cf), .ev_jump_skip(ev_js)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung act=%0d exp=<20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // vector: [40:39] cond strobe (0 none,1 true,2 false), [38] jump strobe,
   // [37:36] first slot, [35] two issues, [34] cond, [33] exc, [32] pc, [31:0] word
   function automatic logic [40:0] mkv(input logic [1:0] f, input logic [14:0] l,
         input logic [14:0] r, input logic pc, input logic exc, input logic cnd,
         input logic two, input logic [1:0] fs, input logic js, input logic [1:0] cs);
      return {cs, js, fs, two, cnd, exc, pc, f, l, r};
   endfunction

   // test classes are 4 and 5: 15'h0800 (class 4), 15'h0A55 (class 5)
   localparam logic [40:0] VEC [0:12] = '{
      mkv(2'b11, 15'h5579, 15'h5EF1, 1, 0, 0, 0, 2'd2, 0, 2'd0), // R1 long
      mkv(2'b01, 15'h1234, 15'h2345, 0, 0, 0, 1, 2'd0, 0, 2'd0), // R2 left first
      mkv(2'b01, 15'h1234, 15'h2345, 1, 0, 0, 0, 2'd0, 1, 2'd0), // R4 pc skip
      mkv(2'b01, 15'h7F01, 15'h2345, 1, 1, 0, 0, 2'd0, 0, 2'd0), // R4 pc+exc
      mkv(2'b10, 15'h1234, 15'h7F01, 0, 0, 0, 1, 2'd1, 0, 2'd0), // R3 right first
      mkv(2'b10, 15'h1234, 15'h7F01, 1, 0, 0, 0, 2'd1, 1, 2'd0), // R4 rl pc skip
      mkv(2'b00, 15'h1234, 15'h2345, 1, 0, 0, 1, 2'd0, 0, 2'd0), // R5 pc ignored
      mkv(2'b00, 15'h1234, 15'h2345, 0, 1, 0, 0, 2'd0, 0, 2'd0), // R5 exc
      mkv(2'b00, 15'h0800, 15'h2345, 0, 0, 1, 1, 2'd0, 0, 2'd1), // R6 true
      mkv(2'b00, 15'h0801, 15'h2345, 0, 0, 0, 0, 2'd0, 0, 2'd2), // R6 false
      mkv(2'b00, 15'h1234, 15'h0A55, 0, 0, 1, 1, 2'd1, 0, 2'd1), // R7 true
      mkv(2'b00, 15'h1234, 15'h0A55, 0, 1, 0, 0, 2'd1, 0, 2'd2), // R7 false+exc
      mkv(2'b00, 15'h0800, 15'h0A55, 0, 0, 1, 1, 2'd0, 0, 2'd1)  // R7 both tests
   };

   function automatic logic [29:0] exp_pay(input logic [31:0] w, input logic [1:0] s);
      if (s == 2'd2) return w[29:0];
      if (s == 2'd0) return {15'b0, w[29:15]};
      return {15'b0, w[14:0]};
   endfunction

   function automatic logic [5:0] exp_cls(input logic [31:0] w, input logic [1:0] s);
      return (s == 2'd1) ? w[14:9] : w[29:24];
   endfunction

   task automatic issue_chk(input string req, input logic [31:0] w,
                            input logic [1:0] s, input logic p);
      chk({req, " iss_valid"}, {31'b0, iss_valid}, 32'd1);
      chk({req, " slot"}, {30'b0, iss_slot}, {30'b0, s});
      chk({req, " pos"}, {31'b0, iss_pos}, {31'b0, p});
      chk({req, " payload"}, {2'b0, iss_payload}, {2'b0, exp_pay(w, s)});
      chk({req, " class"}, {26'b0, iss_class}, {26'b0, exp_cls(w, s)});
   endtask

   task automatic offer(input logic [31:0] w);
      word_data  = w;
      word_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      word_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 word_ready in reset", {31'b0, word_ready}, 32'd1);
      chk("R10 iss_valid in reset", {31'b0, iss_valid}, 32'd0);
      chk("R10 strobes in reset", {25'b0, ev_long, ev_lr, ev_rl, ev_par, ev_ct, ev_cf, ev_js}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 word_ready after reset", {31'b0, word_ready}, 32'd1);

      for (int i = 0; i < 13; i++) begin
         logic [40:0] v;
         logic [31:0] w;
         logic [1:0]  fs, cs;
         v  = VEC[i];
         w  = v[31:0];
         fs = v[37:36];
         cs = v[40:39];
         offer(w);
         // R8 accepted word shows first issue next cycle, R9 format strobe
         chk("R8 word_ready busy", {31'b0, word_ready}, 32'd0);
         issue_chk("R1/R2/R3/R5/R6/R7 first", w, fs, 1'b0);
         chk("R9 format strobe", {28'b0, ev_long, ev_lr, ev_rl, ev_par},
             {28'b0, w[31:30] == 2'b11, w[31:30] == 2'b01, w[31:30] == 2'b10, w[31:30] == 2'b00});
         fb_pc = v[32]; fb_exc = v[33]; fb_cond = v[34];
         @(posedge clk);
         @(negedge clk);
         fb_pc = 1'b0; fb_exc = 1'b0; fb_cond = 1'b0;
         chk("R4 jump strobe", {31'b0, ev_js}, {31'b0, v[38]});
         chk("R6 R7 cond strobes", {30'b0, ev_ct, ev_cf}, {30'b0, cs == 2'd1, cs == 2'd2});
         chk("R9 format strobe one cycle", {28'b0, ev_long, ev_lr, ev_rl, ev_par}, 32'd0);
         if (v[35]) begin
            issue_chk("R2/R3/R5/R6/R7 second", w, (fs == 2'd0) ? 2'd1 : 2'd0, 1'b1);
            @(posedge clk);
            @(negedge clk);
         end else begin
            chk("R4/R5/R6/R7 suppressed", {31'b0, iss_valid}, 32'd0);
         end
         chk("R8 idle after word", {31'b0, word_ready}, 32'd1);
      end

      // R8 backpressure: outputs hold while iss_ready is low
      iss_ready = 1'b0;
      offer({2'b10, 15'h1357, 15'h2468});
      repeat (2) begin
         @(posedge clk);
         @(negedge clk);
         issue_chk("R8 stall hold", {2'b10, 15'h1357, 15'h2468}, 2'd1, 1'b0);
         chk("R8 no accept while busy", {31'b0, word_ready}, 32'd0);
      end
      iss_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      issue_chk("R3 second after stall", {2'b10, 15'h1357, 15'h2468}, 2'd0, 1'b1);
      @(posedge clk);
      @(negedge clk);
      chk("R8 idle after stall", {31'b0, word_ready}, 32'd1);

      // R10 reset mid-word returns to idle
      offer({2'b01, 15'h1111, 15'h2222});
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R10 reset mid-word iss_valid", {31'b0, iss_valid}, 32'd0);
      chk("R10 reset mid-word ready", {31'b0, word_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule